// File: doc/BRIEF.md
# Eight-Channel DAC Control Register Bank

This block is the register file behind a serially programmed eight-channel DAC controller. A serial front end outside the block has already turned each frame into a 5-bit register address and a 16-bit data word. The block decodes that pair into single-cycle writes. Reads are a combinational lookup on the address. The block holds a configuration register, two offset registers, a serial-mode register, a broadcast address and eight per-channel input data registers. Each channel register feeds an output latch.

The two offset registers start from trimmed codes. Each register has its own code for each gain setting, and these codes are parameters. In single-supply mode the offset registers are forced to zero. A change of either gain bit reloads its own offset register. The sleep bit in the serial-mode register routes the serial input pin straight to the serial output pin, bypassing the shift logic. The broadcast address writes all eight channel registers in one cycle, but only while correction is disabled.

Top module: `dac_regbank`

## Requirements
- R1: After reset, the configuration register reads 0000h. Offset A and offset B read their gain-6 trim codes when in dual-supply mode. The serial-mode register, all channel registers and all output latches are 0000h.
- R2: While `single_supply_i` is 1, both offset outputs and offset reads return 0000h. Offset writes are discarded, and the stored value reappears unchanged when dual-supply mode returns.
- R3: The configuration register is at address 00h. Bit 0 is correction enable, bit 1 is gain A and bit 2 is gain B (0 = gain 6, 1 = gain 4). The remaining bits read 0. In dual-supply mode, a configuration write that changes gain A reloads offset A with its trim code for the new gain. Gain B and offset B behave the same way, independently. A write that leaves a gain bit unchanged leaves its offset register unchanged.
- R4: In dual-supply mode, offset A (address 01h) and offset B (address 02h) store written data and read it back.
- R5: Serial-mode register, address 03h: bit 15 is the sleep bit. While it is set, `sdo_o` equals `sdi_i`. While it is clear, `sdo_o` equals `shift_sdo_i`. Bits 14:0 read 0.
- R6: While `wakeup_i` is low at a clock edge, the sleep bit is cleared at that edge. A write that tries to set it in that same cycle has no effect.
- R7: A write to address 07h loads the data into all eight channel registers at one edge, but only when correction enable is 0. When correction enable is 1, the write changes nothing. Reading 07h always returns 0000h.
- R8: Channel register n sits at address 08h+n (n = 0..7), is 16 bits wide and reads back what was written.
- R9: At a clock edge where `load_ch_i[n]` or `load_all_i` is 1, latch n takes the channel-n value held before that edge. Latch n occupies bits 16n+15:16n of `dac_data_o`.
- R10: Addresses 04h-06h and 10h-1Fh read 0000h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for addr_i/wdata_i |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| single_supply_i | input | 1 | 1 = single-supply mode |
| wakeup_i | input | 1 | Low clears the sleep bit |
| sdi_i | input | 1 | Serial data input pin |
| shift_sdo_i | input | 1 | Serial output from shift logic |
| sdo_o | output | 1 | Serial data output pin |
| load_all_i | input | 1 | Load all output latches |
| load_ch_i | input | 8 | Per-channel latch load |
| offset_a_o | output | 16 | Offset A value to its DAC |
| offset_b_o | output | 16 | Offset B value to its DAC |
| dac_data_o | output | 128 | Eight output latches, channel 0 in LSBs |

## Verification
Directed sequences first cover the behaviours that depend on mode. Gain flips show whether each offset reloads on its own or both reload together, and repeated writes of an unchanged gain show whether a reload happens without a real change. A supply toggle wrapped around an offset write shows whether the write is masked or truly discarded. A broadcast issued with correction enabled and then disabled separates the two sides of the enable. After that, seeded random writes to all 32 addresses are mixed with random latch strobes, supply flips, wakeup pulses and serial bits. These stress overlaps such as a write and a load at the same edge, and a sleep write while wakeup is held low, against a reference model.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
  localparam int AW = 5;
  localparam logic [AW-1:0] ADDR_CFG     = 5'h00;
  localparam logic [AW-1:0] ADDR_OFS_A   = 5'h01;
  localparam logic [AW-1:0] ADDR_OFS_B   = 5'h02;
  localparam logic [AW-1:0] ADDR_MODE    = 5'h03;
  localparam logic [AW-1:0] ADDR_BCAST   = 5'h07;
  localparam int            ADDR_CH_BASE = 8;

  typedef struct packed {
    logic gain_b;
    logic gain_a;
    logic corr_en;
  } cfg_t;
endpackage

// File: rtl/dac_offset_reg.sv
module dac_offset_reg #(
  parameter int            DW      = 16,
  parameter logic [DW-1:0] TRIM_G6 = '0,
  parameter logic [DW-1:0] TRIM_G4 = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          single_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          gain_cur_i,
  input  logic          gain_wr_i,
  input  logic          gain_new_i,
  output logic [DW-1:0] val_o
);
  logic [DW-1:0] q;
  logic          reload;

  assign reload = gain_wr_i && (gain_new_i != gain_cur_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= TRIM_G6;
    else if (!single_i) begin
      if (reload)    q <= gain_new_i ? TRIM_G4 : TRIM_G6;
      else if (wr_i) q <= wdata_i;
    end
  end

  assign val_o = single_i ? '0 : q;
endmodule

// File: rtl/dac_mode_reg.sv
module dac_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic sleep_d_i,
  input  logic wakeup_i,
  input  logic sdi_i,
  input  logic shift_sdo_i,
  output logic sleep_o,
  output logic sdo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sleep_o <= 1'b0;
    else if (!wakeup_i) sleep_o <= 1'b0;
    else if (wr_i)     sleep_o <= sleep_d_i;
  end

  // bypass: pin-to-pin path while asleep
  assign sdo_o = sleep_o ? sdi_i : shift_sdo_i;
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank #(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCH-1:0]          wr_ch_i,
  input  logic                    bcast_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NCH-1:0]          load_i,
  output logic [NCH-1:0][DW-1:0]  chan_o,
  output logic [NCH-1:0][DW-1:0]  lat_o
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    chan_o[n] <= '0;
      else if (bcast_i || wr_ch_i[n]) chan_o[n] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lat_o[n] <= '0;
      else if (load_i[n]) lat_o[n] <= chan_o[n];
    end
  end
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int            NCH       = 8,
  parameter int            DW        = 16,
  parameter logic [DW-1:0] TRIM_A_G6 = 16'h999A,
  parameter logic [DW-1:0] TRIM_A_G4 = 16'hAAAB,
  parameter logic [DW-1:0] TRIM_B_G6 = 16'h9997,
  parameter logic [DW-1:0] TRIM_B_G4 = 16'hAAAE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              single_supply_i,
  input  logic              wakeup_i,
  input  logic              sdi_i,
  input  logic              shift_sdo_i,
  output logic              sdo_o,
  input  logic              load_all_i,
  input  logic [NCH-1:0]    load_ch_i,
  output logic [DW-1:0]     offset_a_o,
  output logic [DW-1:0]     offset_b_o,
  output logic [NCH*DW-1:0] dac_data_o
);
  localparam int CFGW = $bits(cfg_t);

  cfg_t                   cfg_q, cfg_d;
  logic                   cfg_wr, ofs_a_wr, ofs_b_wr, mode_wr, bcast_wr;
  logic                   sleep_q;
  logic [NCH-1:0]         wr_ch;
  logic [NCH-1:0][DW-1:0] chan_q, lat_q;

  assign cfg_d    = cfg_t'(wdata_i[CFGW-1:0]);
  assign cfg_wr   = wr_en_i && (addr_i == ADDR_CFG);
  assign ofs_a_wr = wr_en_i && (addr_i == ADDR_OFS_A);
  assign ofs_b_wr = wr_en_i && (addr_i == ADDR_OFS_B);
  assign mode_wr  = wr_en_i && (addr_i == ADDR_MODE);
  assign bcast_wr = wr_en_i && (addr_i == ADDR_BCAST) && !cfg_q.corr_en;

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign wr_ch[n] = wr_en_i && (addr_i == AW'(ADDR_CH_BASE + n));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_d;
  end

  dac_offset_reg #(.DW(DW), .TRIM_G6(TRIM_A_G6), .TRIM_G4(TRIM_A_G4)) u_ofs_a (
    .clk_i, .rst_ni,
    .single_i   (single_supply_i),
    .wr_i       (ofs_a_wr),
    .wdata_i    (wdata_i),
    .gain_cur_i (cfg_q.gain_a),
    .gain_wr_i  (cfg_wr),
    .gain_new_i (cfg_d.gain_a),
    .val_o      (offset_a_o)
  );

  dac_offset_reg #(.DW(DW), .TRIM_G6(TRIM_B_G6), .TRIM_G4(TRIM_B_G4)) u_ofs_b (
    .clk_i, .rst_ni,
    .single_i   (single_supply_i),
    .wr_i       (ofs_b_wr),
    .wdata_i    (wdata_i),
    .gain_cur_i (cfg_q.gain_b),
    .gain_wr_i  (cfg_wr),
    .gain_new_i (cfg_d.gain_b),
    .val_o      (offset_b_o)
  );

  dac_mode_reg u_mode (
    .clk_i, .rst_ni,
    .wr_i        (mode_wr),
    .sleep_d_i   (wdata_i[DW-1]),
    .wakeup_i    (wakeup_i),
    .sdi_i       (sdi_i),
    .shift_sdo_i (shift_sdo_i),
    .sleep_o     (sleep_q),
    .sdo_o       (sdo_o)
  );

  dac_chan_bank #(.NCH(NCH), .DW(DW)) u_chan (
    .clk_i, .rst_ni,
    .wr_ch_i (wr_ch),
    .bcast_i (bcast_wr),
    .wdata_i (wdata_i),
    .load_i  (load_ch_i | {NCH{load_all_i}}),
    .chan_o  (chan_q),
    .lat_o   (lat_q)
  );

  assign dac_data_o = lat_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CFG:   rdata_o = DW'(cfg_q);
      ADDR_OFS_A: rdata_o = offset_a_o;
      ADDR_OFS_B: rdata_o = offset_b_o;
      ADDR_MODE:  rdata_o = {sleep_q, {(DW-1){1'b0}}};
      default: begin
        for (int n = 0; n < NCH; n++)
          if (addr_i == AW'(ADDR_CH_BASE + n)) rdata_o = chan_q[n];
      end
    endcase
  end
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
  parameter int            NCH       = 8,
  parameter int            DW        = 16,
  parameter logic [DW-1:0] TRIM_A_G4 = '0,
  parameter logic [DW-1:0] TRIM_A_G6 = '0
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [4:0]             addr_i,
  input logic [DW-1:0]          wdata_i,
  input logic                   single_supply_i,
  input logic                   wakeup_i,
  input logic                   sdi_i,
  input logic                   sdo_o,
  input logic                   load_all_i,
  input logic [DW-1:0]          offset_a_o,
  input logic [DW-1:0]          offset_b_o,
  input logic [NCH*DW-1:0]      dac_data_o,
  input logic [2:0]             cfg_q,
  input logic                   sleep_q,
  input logic [NCH*DW-1:0]      chan_q
);
  AST_OFS_ZERO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_supply_i |-> (offset_a_o == '0 && offset_b_o == '0)); // R2

  AST_GAIN_A_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 5'h00 && !single_supply_i && wdata_i[1] != cfg_q[1])
    |=> (single_supply_i || offset_a_o == (cfg_q[1] ? TRIM_A_G4 : TRIM_A_G6))); // R3

  AST_SDO_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_q |-> sdo_o == sdi_i); // R5

  AST_WAKEUP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wakeup_i |=> !sleep_q); // R6

  AST_BCAST_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 5'h07 && !cfg_q[0]) |=> chan_q == {NCH{$past(wdata_i)}}); // R7

  AST_LOAD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_all_i |=> dac_data_o == $past(chan_q)); // R9
endmodule

bind dac_regbank dac_regbank_chk #(
  .NCH(NCH), .DW(DW), .TRIM_A_G4(TRIM_A_G4), .TRIM_A_G6(TRIM_A_G6)
) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .single_supply_i,
  .wakeup_i, .sdi_i, .sdo_o, .load_all_i, .offset_a_o, .offset_b_o,
  .dac_data_o,
  .cfg_q   (cfg_q),
  .sleep_q (sleep_q),
  .chan_q  (chan_q)
);

// File: tb/dac_regbank_bench.sv
module dac_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 16;
  localparam logic [15:0] TA6 = 16'h999A, TA4 = 16'hAAAB, TB6 = 16'h9997, TB4 = 16'hAAAE;

  logic clk_i = 0, rst_ni = 0;
  logic wr_en_i = 0;
  logic [4:0] addr_i = 0;
  logic [15:0] wdata_i = 0;
  logic [15:0] rdata_o;
  logic single_supply_i = 0, wakeup_i = 1, sdi_i = 0, shift_sdo_i = 0, sdo_o;
  logic load_all_i = 0;
  logic [NCH-1:0] load_ch_i = 0;
  logic [15:0] offset_a_o, offset_b_o;
  logic [NCH*DW-1:0] dac_data_o;

  int n_chk = 0, n_fail = 0;

  // reference state
  logic [2:0]  m_cfg;
  logic [15:0] m_ofs [2];
  logic        m_sleep;
  logic [15:0] m_ch  [NCH];
  logic [15:0] m_lat [NCH];

  dac_regbank u_dac_regbank (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [15:0] trim(input int r, input logic g4);
    if (r == 0) return g4 ? TA4 : TA6;
    return g4 ? TB4 : TB6;
  endfunction

  function automatic logic [15:0] rd_exp(input logic [4:0] a);
    if (a == 5'h00) return {13'b0, m_cfg};
    if (a == 5'h01) return single_supply_i ? 16'h0 : m_ofs[0];
    if (a == 5'h02) return single_supply_i ? 16'h0 : m_ofs[1];
    if (a == 5'h03) return {m_sleep, 15'b0};
    if (a >= 5'h08 && a <= 5'h0F) return m_ch[a - 5'h08];
    return 16'h0; // broadcast and unmapped
  endfunction

  function automatic string rd_tag(input logic [4:0] a);
    if (a == 5'h00) return "R3";
    if (a == 5'h01 || a == 5'h02) return "R2/R4";
    if (a == 5'h03) return "R5";
    if (a == 5'h07) return "R7";
    if (a >= 5'h08 && a <= 5'h0F) return "R8";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [NCH*DW-1:0] act, input logic [NCH*DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cfg = 0; m_ofs[0] = TA6; m_ofs[1] = TB6; m_sleep = 0;
    for (int n = 0; n < NCH; n++) begin m_ch[n] = 0; m_lat[n] = 0; end
  endtask

  task automatic model_step();
    for (int n = 0; n < NCH; n++)
      if (load_all_i || load_ch_i[n]) m_lat[n] = m_ch[n];
    if (wr_en_i) begin
      case (addr_i)
        5'h00: begin
          if (!single_supply_i) begin
            if (wdata_i[1] != m_cfg[1]) m_ofs[0] = trim(0, wdata_i[1]);
            if (wdata_i[2] != m_cfg[2]) m_ofs[1] = trim(1, wdata_i[2]);
          end
          m_cfg = wdata_i[2:0];
        end
        5'h01: if (!single_supply_i) m_ofs[0] = wdata_i;
        5'h02: if (!single_supply_i) m_ofs[1] = wdata_i;
        5'h03: m_sleep = wdata_i[15];
        5'h07: if (!m_cfg[0]) for (int n = 0; n < NCH; n++) m_ch[n] = wdata_i;
        default: if (addr_i >= 5'h08 && addr_i <= 5'h0F) m_ch[addr_i - 5'h08] = wdata_i;
      endcase
    end
    if (!wakeup_i) m_sleep = 0;
  endtask

  task automatic check_all();
    logic [NCH*DW-1:0] lat_exp;
    for (int n = 0; n < NCH; n++) lat_exp[n*DW +: DW] = m_lat[n];
    chk("R9 latches", dac_data_o, lat_exp);
    chk("R2 offset_a_o", 128'(offset_a_o), 128'(single_supply_i ? 16'h0 : m_ofs[0]));
    chk("R2 offset_b_o", 128'(offset_b_o), 128'(single_supply_i ? 16'h0 : m_ofs[1]));
    chk("R5 sdo_o", 128'(sdo_o), 128'(m_sleep ? sdi_i : shift_sdo_i));
    chk(rd_tag(addr_i), 128'(rdata_o), 128'(rd_exp(addr_i)));
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    check_all();
    wr_en_i = 0; load_all_i = 0; load_ch_i = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    tick();
  endtask

  task automatic peek(input string tag, input logic [4:0] a);
    addr_i = a; #1;
    chk(tag, 128'(rdata_o), 128'(rd_exp(a)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    // R1: reset state
    for (int a = 0; a < 16; a++) peek("R1", 5'(a));
    check_all();

    // R4: offset write/read in dual mode
    wr(5'h01, 16'h1234); peek("R4", 5'h01);
    wr(5'h02, 16'hBEEF); peek("R4", 5'h02);

    // R3: independent reloads
    wr(5'h00, 16'h0002); peek("R3", 5'h01); peek("R3", 5'h02);
    chk("R3 ofs A g4", 128'(offset_a_o), 128'(TA4));
    chk("R3 ofs B kept", 128'(offset_b_o), 128'(16'hBEEF));
    wr(5'h01, 16'h0F0F);
    wr(5'h00, 16'h0002); // gain unchanged
    chk("R3 no reload", 128'(offset_a_o), 128'(16'h0F0F));
    wr(5'h00, 16'h0004);
    chk("R3 ofs A g6", 128'(offset_a_o), 128'(TA6));
    chk("R3 ofs B g4", 128'(offset_b_o), 128'(TB4));

    // R2: single-supply masking and discard
    single_supply_i = 1;
    wr(5'h01, 16'h5555); peek("R2", 5'h01);
    wr(5'h00, 16'h0000); // gain change ignored for offsets
    single_supply_i = 0; #1;
    peek("R2", 5'h01); peek("R2", 5'h02);

    // R5: sleep bypass
    wr(5'h03, 16'hFFFF); peek("R5", 5'h03);
    sdi_i = 1; shift_sdo_i = 0; #1; chk("R5 bypass", 128'(sdo_o), 128'(1));
    sdi_i = 0; shift_sdo_i = 1; #1; chk("R5 bypass", 128'(sdo_o), 128'(0));

    // R6: wakeup low clears and blocks set
    wakeup_i = 0; tick(); peek("R6", 5'h03);
    wr(5'h03, 16'h8000); peek("R6", 5'h03);
    chk("R6 sdo", 128'(sdo_o), 128'(shift_sdo_i));
    wakeup_i = 1;

    // R7: broadcast
    wr(5'h07, 16'hA5C3);
    for (int a = 8; a < 16; a++) peek("R7", 5'(a));
    peek("R7", 5'h07);
    wr(5'h00, 16'h0001);
    wr(5'h07, 16'h1111);
    for (int a = 8; a < 16; a++) peek("R7", 5'(a));
    wr(5'h00, 16'h0000);

    // R8 and R9: per-channel write and load at the same edge
    wr(5'h0A, 16'h7777);
    load_ch_i = 8'h04; wr_en_i = 1; addr_i = 5'h0A; wdata_i = 16'h8888; tick();
    peek("R8", 5'h0A);
    load_all_i = 1; tick();
    chk("R9 load_all ch2", 128'(dac_data_o[2*DW +: DW]), 128'(16'h8888));

    // R10: unmapped
    wr(5'h05, 16'hFFFF); wr(5'h1F, 16'hFFFF); wr(5'h10, 16'hFFFF);
    peek("R10", 5'h05); peek("R10", 5'h1F);
    for (int a = 0; a < 16; a++) peek("R10", 5'(a));

    // random phase
    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      if ($urandom % 4 != 0) begin
        case ($urandom % 6)
          0: a = 5'h00; 1: a = 5'h01 + 5'($urandom % 3);
          2: a = 5'h07; default: a = 5'h08 + 5'($urandom % 8);
        endcase
      end else a = 5'($urandom);
      wr_en_i = ($urandom % 3) != 0;
      addr_i = a;
      wdata_i = (a == 5'h00) ? 16'($urandom % 8) : 16'($urandom);
      load_all_i = ($urandom % 10) == 0;
      load_ch_i = 8'($urandom) & 8'($urandom);
      if ($urandom % 20 == 0) single_supply_i = ~single_supply_i;
      wakeup_i = ($urandom % 12) != 0;
      sdi_i = 1'($urandom); shift_sdo_i = 1'($urandom);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule